// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a 16-bit asynchronous parallel NOR flash bus. It takes one high-level request at a time and expands it into the series of bus accesses the flash command interface expects. The supported requests are return-to-read, identifier read, single-word program, buffered program, sector erase, chip erase and the common-flash-interface query. Each request carries an operation code, a word address, a data word and, for buffered programming, a word count. The block reports acceptance or rejection, holds `busy` while its sequence runs, and pulses `done` when the last access has finished.

Every bus access follows the same four-phase pattern. In the setup phase chip enable is low and both strobes are high. In the strobe phase write enable (or output enable for a read) is low for a configurable number of cycles. In the hold phase chip enable is still low and both strobes are high. In the gap phase chip enable is high. Word addresses leave the block as byte addresses. During a buffered program, the data words come from a host-side buffer that the block indexes through a small read port. Identifier reads hand back the words they capture on a read-data strobe. The block does not poll the flash for completion.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `req_accept`, `req_reject` and `rd_valid` are low, and `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high. Whenever `busy` is low, all three bus controls are high.
- R2: Each access has four phases: one setup cycle with chip enable low and both strobes high, then W strobe cycles, then one hold cycle with chip enable low, then at least one cycle with chip enable high before the next access. W is the value of `cfg_strobe` sampled at acceptance, and a value of 0 counts as 1. Write enable and output enable are never low together.
- R3: Every request except return-to-read and the query begins with two writes: 0xAA to word 0x555, then 0x55 to word 0x2AA.
- R4: Identifier read (op code 1) writes the two unlock words, then 0x90 to word 0x555. It then reads word 0 and word 1, in that order. Each read value appears on `rd_data` with a one-cycle `rd_valid`.
- R5: Single-word program (op code 2) writes the two unlock words, then 0xA0 to word 0x555, then `req_data` to `req_addr`.
- R6: Chip erase (op code 5) is six writes: the unlock pair, 0x80 to 0x555, the unlock pair again, and 0x10 to 0x555.
- R7: Sector erase (op code 4) uses the same first five writes as chip erase. Its sixth write is 0x30 to `req_addr`.
- R8: Buffered program (op code 3, length N from 1 to MAX_BUF) writes the unlock pair, then 0x25 to `req_addr`, then N-1 to `req_addr`. It then writes buffer words 0..N-1 to `req_addr`+0..N-1, and finally 0x29 to `req_addr`+N-1. While word k is fetched, `buf_idx` equals k.
- R9: Return-to-read (op code 0) is a single write of 0xF0 to word 0. The query (op code 6) is a single write of 0x98 to word 0x55. Neither has an unlock pair.
- R10: A request that arrives while `busy` is high gets a one-cycle `req_reject` in the next cycle and no `req_accept`. It does not change the sequence that is running.
- R11: Op code 7 is rejected. A buffered program with length 0 or a length above MAX_BUF is rejected. A rejected request causes no bus access and no `done`.
- R12: An accepted request gets a one-cycle `req_accept` in the next cycle. `done` is a one-cycle pulse in the cycle after the final access's gap phase, and `busy` is low in that same cycle.
- R13: `mem_addr` carries the word address shifted left by one, so bit 0 is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_addr | input | WORD_AW | Target word address |
| req_data | input | 16 | Data word for single-word program |
| req_len | input | LEN_W | Word count for buffered program |
| cfg_strobe | input | PW_W | Strobe length in cycles (0 treated as 1) |
| req_accept | output | 1 | Request taken |
| req_reject | output | 1 | Request refused |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| buf_idx | output | IDX_W | Buffer word index during buffered program |
| buf_word | input | 16 | Buffer word at `buf_idx` |
| rd_valid | output | 1 | Read word captured |
| rd_data | output | 16 | Captured read word |
| mem_addr | output | WORD_AW+1 | Byte address to the flash |
| mem_dout | output | 16 | Write data to the flash |
| mem_din | input | 16 | Read data from the flash |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The bench checks buffered programs at both length limits. With length 1 the count word and the commit address coincide with the start; with MAX_BUF words an off-by-one in the step counter would drop or repeat the commit. It checks a strobe length of zero, which a careless pulse counter would turn into a very long pulse. It compares both erase lists word for word, where a design that reused the wrong final step would erase the whole chip on a sector request. Requests issued mid-sequence and illegal codes or lengths are checked against the bus log to show they leave no trace, and every strobe is checked for a preceding chip-enable-high cycle and for the address shift.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_RESET      = 3'd0,
        OP_READ_ID    = 3'd1,
        OP_PROG       = 3'd2,
        OP_BUF_PROG   = 3'd3,
        OP_SECT_ERASE = 3'd4,
        OP_CHIP_ERASE = 3'd5,
        OP_QUERY      = 3'd6,
        OP_NONE       = 3'd7
    } nor_op_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_GAP    = 3'd4
    } bus_phase_e;

    // one bus access as produced by the step generator
    typedef struct packed {
        logic        rd;
        logic        last;
        logic [15:0] data;
    } bus_op_t;

    localparam logic [11:0] KEY_WADDR_A = 12'h555;
    localparam logic [11:0] KEY_WADDR_B = 12'h2AA;
    localparam logic [11:0] QUERY_WADDR = 12'h055;

    localparam logic [15:0] KEY_DATA_A     = 16'h00AA;
    localparam logic [15:0] KEY_DATA_B     = 16'h0055;
    localparam logic [15:0] CMD_IDENT      = 16'h0090;
    localparam logic [15:0] CMD_WORD_PROG  = 16'h00A0;
    localparam logic [15:0] CMD_ERASE_ARM  = 16'h0080;
    localparam logic [15:0] CMD_ERASE_ALL  = 16'h0010;
    localparam logic [15:0] CMD_ERASE_SECT = 16'h0030;
    localparam logic [15:0] CMD_BUF_LOAD   = 16'h0025;
    localparam logic [15:0] CMD_BUF_COMMIT = 16'h0029;
    localparam logic [15:0] CMD_TO_READ    = 16'h00F0;
    localparam logic [15:0] CMD_QUERY      = 16'h0098;

    // first step of a buffered program that carries a buffer word
    localparam int BUF_DATA_STEP = 4;

    function automatic logic op_known(input logic [2:0] code);
        return code != OP_NONE;
    endfunction

    function automatic bus_op_t wr_op(input logic [15:0] d, input logic fin);
        bus_op_t o;
        o.rd   = 1'b0;
        o.last = fin;
        o.data = d;
        return o;
    endfunction

    function automatic bus_op_t rd_op(input logic fin);
        bus_op_t o;
        o.rd   = 1'b1;
        o.last = fin;
        o.data = 16'h0000;
        return o;
    endfunction

endpackage

// File: rtl/nor_step_gen.sv
module nor_step_gen
    import nor_seq_pkg::*;
#(
    parameter int AW     = 20,
    parameter int LEN_W  = 6,
    parameter int IDX_W  = 5,
    parameter int STEP_W = 7
)(
    input  nor_op_e           op,
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [15:0]       tgt_data,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [15:0]       buf_word,
    output bus_op_t           cyc,
    output logic [AW-1:0]     cyc_addr,
    output logic [IDX_W-1:0]  buf_idx
);

    logic [STEP_W-1:0] off;
    logic [STEP_W-1:0] commit_step;

    assign off         = step - STEP_W'(BUF_DATA_STEP);
    assign commit_step = STEP_W'(len_m1) + STEP_W'(BUF_DATA_STEP + 1);
    assign buf_idx     = off[IDX_W-1:0];

    always_comb begin
        cyc      = wr_op(16'h0000, 1'b1);
        cyc_addr = '0;
        case (op)
            OP_RESET: begin
                cyc      = wr_op(CMD_TO_READ, 1'b1);
                cyc_addr = '0;
            end
            OP_QUERY: begin
                cyc      = wr_op(CMD_QUERY, 1'b1);
                cyc_addr = AW'(QUERY_WADDR);
            end
            default: begin
                // steps 0 and 1 are the unlock pair for every remaining op
                if (step == STEP_W'(0)) begin
                    cyc      = wr_op(KEY_DATA_A, 1'b0);
                    cyc_addr = AW'(KEY_WADDR_A);
                end else if (step == STEP_W'(1)) begin
                    cyc      = wr_op(KEY_DATA_B, 1'b0);
                    cyc_addr = AW'(KEY_WADDR_B);
                end else begin
                    case (op)
                        OP_READ_ID: begin
                            if (step == STEP_W'(2)) begin
                                cyc      = wr_op(CMD_IDENT, 1'b0);
                                cyc_addr = AW'(KEY_WADDR_A);
                            end else if (step == STEP_W'(3)) begin
                                cyc      = rd_op(1'b0);
                                cyc_addr = '0;
                            end else begin
                                cyc      = rd_op(1'b1);
                                cyc_addr = AW'(1);
                            end
                        end
                        OP_PROG: begin
                            if (step == STEP_W'(2)) begin
                                cyc      = wr_op(CMD_WORD_PROG, 1'b0);
                                cyc_addr = AW'(KEY_WADDR_A);
                            end else begin
                                cyc      = wr_op(tgt_data, 1'b1);
                                cyc_addr = tgt_addr;
                            end
                        end
                        OP_SECT_ERASE, OP_CHIP_ERASE: begin
                            if (step == STEP_W'(2)) begin
                                cyc      = wr_op(CMD_ERASE_ARM, 1'b0);
                                cyc_addr = AW'(KEY_WADDR_A);
                            end else if (step == STEP_W'(3)) begin
                                cyc      = wr_op(KEY_DATA_A, 1'b0);
                                cyc_addr = AW'(KEY_WADDR_A);
                            end else if (step == STEP_W'(4)) begin
                                cyc      = wr_op(KEY_DATA_B, 1'b0);
                                cyc_addr = AW'(KEY_WADDR_B);
                            end else if (op == OP_SECT_ERASE) begin
                                cyc      = wr_op(CMD_ERASE_SECT, 1'b1);
                                cyc_addr = tgt_addr;
                            end else begin
                                cyc      = wr_op(CMD_ERASE_ALL, 1'b1);
                                cyc_addr = AW'(KEY_WADDR_A);
                            end
                        end
                        OP_BUF_PROG: begin
                            if (step == STEP_W'(2)) begin
                                cyc      = wr_op(CMD_BUF_LOAD, 1'b0);
                                cyc_addr = tgt_addr;
                            end else if (step == STEP_W'(3)) begin
                                cyc      = wr_op(16'(len_m1), 1'b0);
                                cyc_addr = tgt_addr;
                            end else if (step == commit_step) begin
                                cyc      = wr_op(CMD_BUF_COMMIT, 1'b1);
                                cyc_addr = tgt_addr + AW'(len_m1);
                            end else begin
                                cyc      = wr_op(buf_word, 1'b0);
                                cyc_addr = tgt_addr + AW'(off);
                            end
                        end
                        default: begin
                            cyc      = wr_op(CMD_TO_READ, 1'b1);
                            cyc_addr = '0;
                        end
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/nor_bus_phy.sv
module nor_bus_phy
    import nor_seq_pkg::*;
#(
    parameter int AW   = 20,
    parameter int PW_W = 4
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   st_addr,
    input  logic            st_rd,
    input  logic [15:0]     st_data,
    input  logic [PW_W-1:0] pw,
    input  logic [15:0]     din,
    output logic [AW:0]     addr_o,
    output logic [15:0]     dout,
    output logic            ce_n,
    output logic            we_n,
    output logic            oe_n,
    output logic            fin,
    output logic            rd_stb,
    output logic [15:0]     rd_word
);

    bus_phase_e      ph;
    logic [PW_W-1:0] cnt;
    logic [AW-1:0]   addr_q;
    logic [15:0]     data_q;
    logic            rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_q    <= 1'b0;
            rd_stb  <= 1'b0;
            rd_word <= '0;
        end else begin
            rd_stb <= 1'b0;
            case (ph)
                PH_IDLE, PH_GAP: begin
                    if (start) begin
                        ph     <= PH_SETUP;
                        addr_q <= st_addr;
                        data_q <= st_data;
                        rd_q   <= st_rd;
                    end else begin
                        ph <= PH_IDLE;
                    end
                end
                PH_SETUP: begin
                    ph  <= PH_STROBE;
                    cnt <= PW_W'(1);
                end
                PH_STROBE: begin
                    if (cnt >= pw) begin
                        ph <= PH_HOLD;
                        if (rd_q) begin
                            rd_stb  <= 1'b1;
                            rd_word <= din;
                        end
                    end else begin
                        cnt <= cnt + PW_W'(1);
                    end
                end
                PH_HOLD: ph <= PH_GAP;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign addr_o = {addr_q, 1'b0};
    assign dout   = data_q;
    assign ce_n   = (ph == PH_IDLE) || (ph == PH_GAP);
    assign we_n   = !((ph == PH_STROBE) && !rd_q);
    assign oe_n   = !((ph == PH_STROBE) && rd_q);
    assign fin    = (ph == PH_GAP);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter  int WORD_AW = 20,
    parameter  int MAX_BUF = 32,
    parameter  int PW_W    = 4,
    localparam int LEN_W   = $clog2(MAX_BUF + 1),
    localparam int IDX_W   = $clog2(MAX_BUF),
    localparam int STEP_W  = LEN_W + 1
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [WORD_AW-1:0] req_addr,
    input  logic [15:0]        req_data,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [PW_W-1:0]    cfg_strobe,
    output logic               req_accept,
    output logic               req_reject,
    output logic               busy,
    output logic               done,
    output logic [IDX_W-1:0]   buf_idx,
    input  logic [15:0]        buf_word,
    output logic               rd_valid,
    output logic [15:0]        rd_data,
    output logic [WORD_AW:0]   mem_addr,
    output logic [15:0]        mem_dout,
    input  logic [15:0]        mem_din,
    output logic               mem_ce_n,
    output logic               mem_we_n,
    output logic               mem_oe_n
);

    nor_op_e            op_q;
    logic [WORD_AW-1:0] addr_q;
    logic [15:0]        data_q;
    logic [LEN_W-1:0]   len_m1_q;
    logic [PW_W-1:0]    pw_q;
    logic [STEP_W-1:0]  step_q;
    logic               last_q;
    logic               kick_q;

    logic               len_ok;
    logic               legal;
    logic               take;
    logic               launch;
    logic               phy_fin;
    bus_op_t            cyc;
    logic [WORD_AW-1:0] cyc_addr;

    assign len_ok = (req_len != '0) && (req_len <= LEN_W'(MAX_BUF));
    assign legal  = op_known(req_op) && ((req_op != OP_BUF_PROG) || len_ok);
    assign take   = req_valid && !busy && legal;
    assign launch = kick_q || (phy_fin && !last_q && busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q       <= OP_RESET;
            addr_q     <= '0;
            data_q     <= '0;
            len_m1_q   <= '0;
            pw_q       <= PW_W'(1);
            step_q     <= '0;
            last_q     <= 1'b0;
            kick_q     <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            req_accept <= 1'b0;
            req_reject <= 1'b0;
        end else begin
            req_accept <= take;
            req_reject <= req_valid && !take;
            done       <= 1'b0;
            kick_q     <= 1'b0;
            if (take) begin
                op_q     <= nor_op_e'(req_op);
                addr_q   <= req_addr;
                data_q   <= req_data;
                len_m1_q <= req_len - LEN_W'(1);
                pw_q     <= (cfg_strobe == '0) ? PW_W'(1) : cfg_strobe;
                step_q   <= '0;
                last_q   <= 1'b0;
                kick_q   <= 1'b1;
                busy     <= 1'b1;
            end else if (launch) begin
                step_q <= step_q + STEP_W'(1);
                last_q <= cyc.last;
            end
            if (busy && phy_fin && last_q) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    nor_step_gen #(
        .AW     (WORD_AW),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W),
        .STEP_W (STEP_W)
    ) u_steps (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .len_m1   (len_m1_q),
        .buf_word (buf_word),
        .cyc      (cyc),
        .cyc_addr (cyc_addr),
        .buf_idx  (buf_idx)
    );

    nor_bus_phy #(
        .AW   (WORD_AW),
        .PW_W (PW_W)
    ) u_phy (
        .clk     (clk),
        .rst     (rst),
        .start   (launch),
        .st_addr (cyc_addr),
        .st_rd   (cyc.rd),
        .st_data (cyc.data),
        .pw      (pw_q),
        .din     (mem_din),
        .addr_o  (mem_addr),
        .dout    (mem_dout),
        .ce_n    (mem_ce_n),
        .we_n    (mem_we_n),
        .oe_n    (mem_oe_n),
        .fin     (phy_fin),
        .rd_stb  (rd_valid),
        .rd_word (rd_data)
    );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic       req_accept,
    input logic       req_reject,
    input logic       busy,
    input logic       done,
    input logic       mem_ce_n,
    input logic       mem_we_n,
    input logic       mem_oe_n
);

    assert_bus_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_ce_n && mem_we_n && mem_oe_n));

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n));

    assert_setup_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> (mem_we_n && mem_oe_n));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_ce_n);

    assert_busy_reject_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> (req_reject && !req_accept));

    assert_bad_code_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd7) |=> req_reject);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_accept (req_accept),
    .req_reject (req_reject),
    .busy       (busy),
    .done       (done),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 20;
    localparam int MAXB = 32;
    localparam int PWW  = 4;
    localparam int LW   = $clog2(MAXB + 1);
    localparam int IW   = $clog2(MAXB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic [LW-1:0] req_len = '0;
    logic [PWW-1:0] cfg_strobe = '0;
    logic          req_accept, req_reject, busy, done, rd_valid;
    logic [IW-1:0] buf_idx;
    logic [15:0]   buf_word, rd_data, mem_dout, mem_din;
    logic [AW:0]   mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign buf_word = 16'hB000 + 16'(buf_idx);
    assign mem_din  = (mem_addr == '0) ? 16'h0001 :
                      (mem_addr == (AW+1)'(2)) ? 16'h227E : 16'hDEAD;

    nor_cmd_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
        .cfg_strobe(cfg_strobe), .req_accept(req_accept), .req_reject(req_reject),
        .busy(busy), .done(done), .buf_idx(buf_idx), .buf_word(buf_word),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // bus monitor log
    logic [AW:0] lg_a [256];
    logic [15:0] lg_d [256];
    bit          lg_r [256];
    bit          lg_g [256];
    int          lg_w [256];
    int          lg_n = 0;
    logic [15:0] rl [16];
    int          rl_n = 0;
    int          done_n = 0;
    int          done_busy = 0;
    bit          strobe_p = 1'b0;
    bit          ce_seen = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_ce_n) ce_seen = 1'b1;
            if (!mem_we_n || !mem_oe_n) begin
                if (!strobe_p) begin
                    if (lg_n < 256) begin
                        lg_a[lg_n] = mem_addr;
                        lg_d[lg_n] = mem_dout;
                        lg_r[lg_n] = !mem_oe_n;
                        lg_g[lg_n] = ce_seen;
                        lg_w[lg_n] = 1;
                        lg_n++;
                    end
                    ce_seen = 1'b0;
                end else if (lg_n > 0) begin
                    lg_w[lg_n-1]++;
                end
                strobe_p = 1'b1;
            end else begin
                strobe_p = 1'b0;
            end
            if (rd_valid && rl_n < 16) begin
                rl[rl_n] = rd_data;
                rl_n++;
            end
            if (done) begin
                done_n++;
                if (busy) done_busy++;
            end
        end
    end

    // expected access list
    logic [AW:0] ex_a [64];
    logic [15:0] ex_d [64];
    bit          ex_r [64];
    int          ex_n;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic push(input int wa, input int d, input bit r);
        ex_a[ex_n] = (AW+1)'(wa) << 1;
        ex_d[ex_n] = 16'(d);
        ex_r[ex_n] = r;
        ex_n++;
    endtask

    task automatic push_unlock();
        push('h555, 'hAA, 0);
        push('h2AA, 'h55, 0);
    endtask

    task automatic cmp_log(input string rq, input int base, input int width);
        chk(lg_n - base == ex_n, rq, "access count", lg_n - base, ex_n);
        for (int i = 0; i < ex_n && base + i < lg_n; i++) begin
            chk(lg_a[base+i] == ex_a[i], {rq, "/R13"}, $sformatf("address #%0d", i),
                lg_a[base+i], ex_a[i]);
            chk(lg_r[base+i] == ex_r[i], rq, $sformatf("direction #%0d", i),
                lg_r[base+i], ex_r[i]);
            if (!ex_r[i])
                chk(lg_d[base+i] == ex_d[i], rq, $sformatf("data #%0d", i),
                    lg_d[base+i], ex_d[i]);
            chk(lg_g[base+i], "R2", $sformatf("ce-high gap before #%0d", i), lg_g[base+i], 1);
            chk(lg_w[base+i] == width, "R2", $sformatf("strobe width #%0d", i),
                lg_w[base+i], width);
        end
    endtask

    task automatic issue(input logic [2:0] op, input int a, input int d,
                         input int len, input int pw, output bit acc, output bit rej);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_addr   = AW'(a);
        req_data   = 16'(d);
        req_len    = LW'(len);
        cfg_strobe = PWW'(pw);
        @(negedge clk);
        acc = req_accept;
        rej = req_reject;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R12", "done reached", done, 1);
        @(negedge clk);
        @(negedge clk);
    endtask

    // run one accepted op and compare the bus log against ex_*
    task automatic run_op(input string rq, input logic [2:0] op, input int a, input int d,
                          input int len, input int pw, input int width);
        bit acc, rej;
        int base  = lg_n;
        int dbase = done_n;
        int bbase = done_busy;
        issue(op, a, d, len, pw, acc, rej);
        chk(acc && !rej, "R12", {rq, " accept pulse"}, {acc, rej}, 2'b10);
        chk(busy == 1'b1, "R12", {rq, " busy after accept"}, busy, 1);
        wait_done();
        chk(done_n - dbase == 1, "R12", {rq, " single done"}, done_n - dbase, 1);
        chk(done_busy == bbase, "R12", {rq, " busy low at done"}, done_busy - bbase, 0);
        cmp_log(rq, base, width);
    endtask

    task automatic t_reset_state();
        chk(!busy && !done && !req_accept && !req_reject && !rd_valid, "R1", "status idle",
            {busy, done, req_accept, req_reject, rd_valid}, 0);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "bus controls high",
            {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    endtask

    task automatic t_to_read();
        ex_n = 0;
        push(0, 'hF0, 0);
        run_op("R9 to-read", 3'd0, 'h1234, 0, 1, 1, 1);
    endtask

    task automatic t_query();
        ex_n = 0;
        push('h55, 'h98, 0);
        run_op("R9 query", 3'd6, 'h777, 0, 1, 2, 2);
    endtask

    task automatic t_ident();
        int rb = rl_n;
        ex_n = 0;
        push_unlock();
        push('h555, 'h90, 0);
        push(0, 0, 1);
        push(1, 0, 1);
        run_op("R4 ident", 3'd1, 0, 0, 1, 2, 2);
        chk(lg_d[lg_n-5] == 16'hAA && lg_d[lg_n-4] == 16'h55, "R3", "unlock words",
            {lg_d[lg_n-5], lg_d[lg_n-4]}, 32'h00AA0055);
        chk(rl_n - rb == 2, "R4", "read strobes", rl_n - rb, 2);
        chk(rl[rb] == 16'h0001, "R4", "first id word", rl[rb], 16'h0001);
        chk(rl[rb+1] == 16'h227E, "R4", "second id word", rl[rb+1], 16'h227E);
    endtask

    task automatic t_prog(input int pw, input int width);
        ex_n = 0;
        push_unlock();
        push('h555, 'hA0, 0);
        push('hABCDE, 'h5A3C, 0);
        run_op("R5 program", 3'd2, 'hABCDE, 'h5A3C, 1, pw, width);
    endtask

    task automatic t_erase(input bit sect);
        ex_n = 0;
        push_unlock();
        push('h555, 'h80, 0);
        push_unlock();
        if (sect) begin
            push('h12345, 'h30, 0);
            run_op("R7 sector erase", 3'd4, 'h12345, 0, 1, 1, 1);
        end else begin
            push('h555, 'h10, 0);
            run_op("R6 chip erase", 3'd5, 'h12345, 0, 1, 1, 1);
        end
    endtask

    task automatic t_buf(input int a, input int len);
        ex_n = 0;
        push_unlock();
        push(a, 'h25, 0);
        push(a, len - 1, 0);
        for (int k = 0; k < len; k++) push(a + k, 'hB000 + k, 0);
        push(a + len - 1, 'h29, 0);
        run_op($sformatf("R8 buffered len %0d", len), 3'd3, a, 0, len, 1, 1);
    endtask

    task automatic t_busy();
        bit acc, rej;
        int base = lg_n;
        int dbase = done_n;
        issue(3'd5, 0, 0, 1, 1, acc, rej);
        chk(acc, "R10", "first request accepted", acc, 1);
        repeat (3) @(negedge clk);
        issue(3'd2, 'h100, 'h1111, 1, 1, acc, rej);
        chk(!acc && rej, "R10", "request while busy rejected", {acc, rej}, 2'b01);
        wait_done();
        chk(done_n - dbase == 1, "R10", "one done only", done_n - dbase, 1);
        ex_n = 0;
        push_unlock();
        push('h555, 'h80, 0);
        push_unlock();
        push('h555, 'h10, 0);
        cmp_log("R10 running sequence intact", base, 1);
    endtask

    task automatic t_bad(input logic [2:0] op, input int len, input string what);
        bit acc, rej;
        int base = lg_n;
        int dbase = done_n;
        issue(op, 'h40, 0, len, 1, acc, rej);
        chk(!acc && rej, "R11", {what, " rejected"}, {acc, rej}, 2'b01);
        repeat (12) @(negedge clk);
        chk(lg_n == base, "R11", {what, " no bus access"}, lg_n - base, 0);
        chk(done_n == dbase, "R11", {what, " no done"}, done_n - dbase, 0);
        chk(!busy, "R11", {what, " not busy"}, busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_to_read();
        t_query();
        t_ident();
        t_prog(3, 3);
        t_prog(0, 1);
        t_erase(1'b1);
        t_erase(1'b0);
        t_buf('h00400, 3);
        t_buf('h00800, 1);
        t_buf('h01000, MAXB);
        t_busy();
        t_bad(3'd7, 1, "op code 7");
        t_bad(3'd3, 0, "buffered length 0");
        t_bad(3'd3, MAXB + 1, "buffered length over max");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule